// File: doc/BRIEF.md
# Flash Unlock Command Sequence Decoder

This block sits between a host byte-write path and the control logic of a flash array. It watches every accepted byte write and follows the multi-cycle unlock protocol. Each command starts with the two-step unlock prefix. The prefix can lead to a four-write program command, a three-write identification entry or exit, or a six-write form. The six-write form ends in a chip, sector or page erase, or in a boot-area lock setting. When a sequence completes, the decoder raises exactly one single-cycle strobe. On that same cycle it presents the address and data of the final write on `op_addr` and `op_data`.

The decoder also holds the identification-mode flag and drives the read-data mux. While the flag is set, three low addresses return a vendor code, a device code and a protection status byte instead of array data. Only the low 15 address bits take part in matching command addresses. The full address is handed on, so the operation logic can pick a sector from bits [18:16] or a page from bits [18:12].

The write port is a valid/ready stream. `wr_ready` is held high, so the decoder never applies back-pressure. Every cycle with `wr_valid` high is one write. A write accepted while `busy` is high is dropped without touching the decoder state.

Top module: `flash_cmd_decoder`

## Requirements
- R1: A command starts with the prefix AAh to address 5555h, then 55h to 2AAAh. Only address bits [14:0] are compared, and `wr_ready` is always 1.
- R2: The prefix, then A0h to 5555h, then one further write of any address and data, pulses `prog_go`. On that same cycle, `op_addr` and `op_data` hold the fourth write's address and data.
- R3: The prefix, then 80h to 5555h, then the prefix again, then 10h to 5555h, pulses `erase_chip`.
- R4: The same six-write form with 30h at any address pulses `erase_sector`. With 50h at any address it pulses `erase_page`. In both cases `op_addr` carries the full address of the sixth write, with the sector in bits [18:16] and the page in bits [18:12].
- R5: The six-write form ending in 40h to 5555h pulses `lock64_go`. Ending in 70h to 5555h, it pulses `lock16_go`.
- R6: The prefix, then 90h to 5555h, pulses `id_enter`. `id_mode` reads 1 from that same cycle on.
- R7: Identification mode is left in one of two ways. The first is the prefix, then F0h to 5555h. The second is a single F0h to any address written while no sequence is in progress. Either way pulses `id_exit`, and `id_mode` reads 0 from that cycle on.
- R8: While `id_mode` is 1, `rd_data` depends on `rd_addr`. Address 0 gives DAh and address 1 gives 3Dh. Address 2 gives a status byte: bit0 = `sw_lock64`, bit1 = `sw_lock16`, bit2 = NOT `tbl_n`, bit3 = NOT `wp_n`, bits [7:4] = 0. Any other address gives 00h. While `id_mode` is 0, `rd_data` equals `arr_rdata`.
- R9: A write that does not match the next expected step sends the decoder back to idle. Continuing the old sequence after that completes no command.
- R10: A write accepted while `busy` is 1 is ignored. It produces no strobe and does not change the sequence position or `id_mode`.
- R11: After reset all strobes and `id_mode` are 0. A strobe is high for one cycle only, in the cycle after an accepted write. At most one strobe is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Host byte write present |
| wr_ready | output | 1 | Write accepted (always 1) |
| wr_addr | input | 19 | Write address |
| wr_data | input | 8 | Write data byte |
| busy | input | 1 | An operation is running; writes are ignored |
| erase_chip | output | 1 | Chip erase strobe |
| erase_sector | output | 1 | Sector erase strobe |
| erase_page | output | 1 | Page erase strobe |
| prog_go | output | 1 | Byte program strobe |
| lock64_go | output | 1 | Set 64 KB boot lock strobe |
| lock16_go | output | 1 | Set 16 KB boot lock strobe |
| id_enter | output | 1 | Identification entry strobe |
| id_exit | output | 1 | Identification exit strobe |
| op_addr | output | 19 | Address of the completing write |
| op_data | output | 8 | Data of the completing write |
| id_mode | output | 1 | Identification mode active |
| rd_addr | input | 19 | Read address |
| arr_rdata | input | 8 | Array read data |
| sw_lock64 | input | 1 | 64 KB software lock state |
| sw_lock16 | input | 1 | 16 KB software lock state |
| tbl_n | input | 1 | Top-block lock pin, active low |
| wp_n | input | 1 | Write-protect pin, active low |
| rd_data | output | 8 | Read data to host |

## Verification
The properties assume that `busy`, `wr_valid` and the write fields are stable across each rising edge and free of X after reset. The bench changes every input only on the falling clock edge and holds reset through the first edges. The properties also assume that `rd_addr` and the protection inputs are steady when `rd_data` is compared. The bench drives these as plain levels and changes them only between checks. No property limits what the host writes. The stimulus deliberately includes mismatching addresses, wrong command bytes and writes during `busy`, so the recovery paths are covered.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE, SQ_U1, SQ_U2, SQ_PGM, SQ_E3, SQ_E4, SQ_E5
  } seq_state_e;

  localparam int unsigned MATCH_W = 15;
  localparam logic [MATCH_W-1:0] UNLOCK_ADDR_A = 15'h5555;
  localparam logic [MATCH_W-1:0] UNLOCK_ADDR_B = 15'h2AAA;

  localparam logic [7:0] BYTE_UNLOCK_A = 8'hAA;
  localparam logic [7:0] BYTE_UNLOCK_B = 8'h55;
  localparam logic [7:0] BYTE_PROGRAM  = 8'hA0;
  localparam logic [7:0] BYTE_SETUP    = 8'h80;
  localparam logic [7:0] BYTE_ID_IN    = 8'h90;
  localparam logic [7:0] BYTE_ID_OUT   = 8'hF0;
  localparam logic [7:0] BYTE_CHIP     = 8'h10;
  localparam logic [7:0] BYTE_SECTOR   = 8'h30;
  localparam logic [7:0] BYTE_PAGE     = 8'h50;
  localparam logic [7:0] BYTE_LOCK64   = 8'h40;
  localparam logic [7:0] BYTE_LOCK16   = 8'h70;

  localparam logic [7:0] CODE_VENDOR = 8'hDA;
  localparam logic [7:0] CODE_DEVICE = 8'h3D;
endpackage

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm
  import flash_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              erase_chip,
  output logic              erase_sector,
  output logic              erase_page,
  output logic              prog_go,
  output logic              lock64_go,
  output logic              lock16_go,
  output logic              id_enter,
  output logic              id_exit,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0] op_data,
  output logic              id_mode
);
  seq_state_e state_q, state_d;
  logic       at_a, at_b;
  logic [7:0] stb_d, stb_q;
  logic       done;

  assign at_a = (addr[MATCH_W-1:0] == UNLOCK_ADDR_A);
  assign at_b = (addr[MATCH_W-1:0] == UNLOCK_ADDR_B);
  assign done = |stb_d;

  // stb bit order: chip, sector, page, prog, lock64, lock16, enter, exit
  always_comb begin
    state_d = state_q;
    stb_d   = '0;
    if (acc) begin
      state_d = SQ_IDLE;
      unique case (state_q)
        SQ_IDLE: begin
          if (at_a && data == BYTE_UNLOCK_A) state_d = SQ_U1;
          else if (data == BYTE_ID_OUT)      stb_d[7] = 1'b1;
        end
        SQ_U1: if (at_b && data == BYTE_UNLOCK_B) state_d = SQ_U2;
        SQ_U2: begin
          if (at_a) begin
            unique case (data)
              BYTE_PROGRAM: state_d  = SQ_PGM;
              BYTE_SETUP:   state_d  = SQ_E3;
              BYTE_ID_IN:   stb_d[6] = 1'b1;
              BYTE_ID_OUT:  stb_d[7] = 1'b1;
              default:      state_d  = SQ_IDLE;
            endcase
          end
        end
        SQ_PGM: stb_d[3] = 1'b1;
        SQ_E3:  if (at_a && data == BYTE_UNLOCK_A) state_d = SQ_E4;
        SQ_E4:  if (at_b && data == BYTE_UNLOCK_B) state_d = SQ_E5;
        SQ_E5: begin
          unique case (data)
            BYTE_CHIP:   stb_d[0] = at_a;
            BYTE_SECTOR: stb_d[1] = 1'b1;
            BYTE_PAGE:   stb_d[2] = 1'b1;
            BYTE_LOCK64: stb_d[4] = at_a;
            BYTE_LOCK16: stb_d[5] = at_a;
            default:     stb_d    = '0;
          endcase
        end
        default: state_d = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      stb_q   <= '0;
      op_addr <= '0;
      op_data <= '0;
      id_mode <= 1'b0;
    end else begin
      state_q <= state_d;
      stb_q   <= stb_d;
      if (done) begin
        op_addr <= addr;
        op_data <= data;
      end
      if (stb_d[6])      id_mode <= 1'b1;
      else if (stb_d[7]) id_mode <= 1'b0;
    end
  end

  assign erase_chip   = stb_q[0];
  assign erase_sector = stb_q[1];
  assign erase_page   = stb_q[2];
  assign prog_go      = stb_q[3];
  assign lock64_go    = stb_q[4];
  assign lock16_go    = stb_q[5];
  assign id_enter     = stb_q[6];
  assign id_exit      = stb_q[7];
endmodule

// File: rtl/flash_id_mux.sv
module flash_id_mux
  import flash_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned DATA_W = 8
) (
  input  logic              id_mode,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] arr_rdata,
  input  logic              sw_lock64,
  input  logic              sw_lock16,
  input  logic              tbl_n,
  input  logic              wp_n,
  output logic [DATA_W-1:0] rd_data
);
  localparam int unsigned PAD_W = DATA_W - 4;
  logic [DATA_W-1:0] id_val;

  always_comb begin
    unique case (rd_addr)
      ADDR_W'(0): id_val = DATA_W'(CODE_VENDOR);
      ADDR_W'(1): id_val = DATA_W'(CODE_DEVICE);
      ADDR_W'(2): id_val = {{PAD_W{1'b0}}, ~wp_n, ~tbl_n, sw_lock16, sw_lock64};
      default:    id_val = '0;
    endcase
  end

  assign rd_data = id_mode ? id_val : arr_rdata;
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              busy,
  output logic              erase_chip,
  output logic              erase_sector,
  output logic              erase_page,
  output logic              prog_go,
  output logic              lock64_go,
  output logic              lock16_go,
  output logic              id_enter,
  output logic              id_exit,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0] op_data,
  output logic              id_mode,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] arr_rdata,
  input  logic              sw_lock64,
  input  logic              sw_lock16,
  input  logic              tbl_n,
  input  logic              wp_n,
  output logic [DATA_W-1:0] rd_data
);
  logic acc;

  assign wr_ready = 1'b1;
  assign acc      = wr_valid && wr_ready && !busy;

  flash_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .acc(acc), .addr(wr_addr), .data(wr_data),
    .erase_chip(erase_chip), .erase_sector(erase_sector),
    .erase_page(erase_page), .prog_go(prog_go), .lock64_go(lock64_go),
    .lock16_go(lock16_go), .id_enter(id_enter), .id_exit(id_exit),
    .op_addr(op_addr), .op_data(op_data), .id_mode(id_mode)
  );

  flash_id_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_idmux (
    .id_mode(id_mode), .rd_addr(rd_addr), .arr_rdata(arr_rdata),
    .sw_lock64(sw_lock64), .sw_lock16(sw_lock16), .tbl_n(tbl_n),
    .wp_n(wp_n), .rd_data(rd_data)
  );
endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk #(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              busy,
  input logic              erase_chip,
  input logic              erase_sector,
  input logic              erase_page,
  input logic              prog_go,
  input logic              lock64_go,
  input logic              lock16_go,
  input logic              id_enter,
  input logic              id_exit,
  input logic [ADDR_W-1:0] op_addr,
  input logic [DATA_W-1:0] op_data,
  input logic              id_mode,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [DATA_W-1:0] rd_data
);
  logic [7:0] stb;
  assign stb = {id_exit, id_enter, lock16_go, lock64_go,
                prog_go, erase_page, erase_sector, erase_chip};

  // R11
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stb));

  // R11
  strobe_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |=> stb == '0);

  // R10
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (stb == '0 && $stable(id_mode)));

  // R1
  ready_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready);

  // R2
  prog_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_go |-> (op_addr == $past(wr_addr) && op_data == $past(wr_data)));

  // R6
  enter_sets_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    id_enter |-> id_mode);

  // R7
  exit_clears_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    id_exit |-> !id_mode);

  // R8
  vendor_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (id_mode && rd_addr == '0) |-> rd_data == 8'hDA);
endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/flash_cmd_decoder_bench.sv
module flash_cmd_decoder_bench;
  localparam int AW = 19;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic wr_ready;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic busy = 1'b0;
  logic erase_chip, erase_sector, erase_page, prog_go;
  logic lock64_go, lock16_go, id_enter, id_exit, id_mode;
  logic [AW-1:0] op_addr;
  logic [7:0] op_data;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0] arr_rdata = 8'h00;
  logic sw_lock64 = 1'b0, sw_lock16 = 1'b0, tbl_n = 1'b1, wp_n = 1'b1;
  logic [7:0] rd_data;

  always #4 clk = ~clk;

  flash_cmd_decoder u_flash_cmd_decoder (.*);

  typedef struct {
    int kind;
    logic [AW-1:0] a;
    logic [7:0] d;
  } ev_t;
  ev_t exp_q[$];

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] expv);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic expect_ev(input int k, input logic [AW-1:0] a, input logic [7:0] d);
    ev_t e;
    e.kind = k; e.a = a; e.d = d;
    exp_q.push_back(e);
  endtask

  task automatic prefix(input logic [AW-1:0] hi);
    wr(hi | 19'h05555, 8'hAA);
    wr(hi | 19'h02AAA, 8'h55);
  endtask

  task automatic six(input logic [AW-1:0] a, input logic [7:0] d);
    prefix('0);
    wr(19'h05555, 8'h80);
    prefix('0);
    wr(a, d);
  endtask

  // monitor: kinds 1 chip,2 sector,3 page,4 prog,5 lock64,6 lock16,7 enter,8 exit
  always @(negedge clk) begin
    if (rst_n && !done) begin
      automatic int cnt = erase_chip + erase_sector + erase_page + prog_go +
                          lock64_go + lock16_go + id_enter + id_exit;
      automatic int k = erase_chip ? 1 : erase_sector ? 2 : erase_page ? 3 :
                        prog_go ? 4 : lock64_go ? 5 : lock16_go ? 6 :
                        id_enter ? 7 : id_exit ? 8 : 0;
      if (cnt > 1) chk(1'b0, "R11 multiple strobes", cnt, 1);
      else if (cnt == 1) begin
        if (exp_q.size() == 0) chk(1'b0, "R9/R10 unexpected strobe", k, 0);
        else begin
          automatic ev_t e = exp_q.pop_front();
          chk(k == e.kind, "R2-R7 strobe kind", k, e.kind);
          if (e.kind >= 2 && e.kind <= 4) begin
            chk(op_addr == e.a, "R2/R4 op_addr", op_addr, e.a);
            chk(op_data == e.d, "R2/R4 op_data", op_data, e.d);
          end
        end
      end
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1'b1;
      chk(1'b0, "watchdog", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(id_mode == 1'b0, "R11 id_mode after reset", id_mode, 0);
    chk({erase_chip, erase_sector, erase_page, prog_go, lock64_go, lock16_go,
         id_enter, id_exit} == 8'h00, "R11 strobes after reset", 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(wr_ready == 1'b1, "R1 wr_ready", wr_ready, 1);
    arr_rdata = 8'h6C;
    rd_addr = 19'h0;
    @(negedge clk);
    chk(rd_data == 8'h6C, "R8 passthrough", rd_data, 8'h6C);

    // R1 R2: upper address bits ignored in matching
    expect_ev(4, 19'h4ABCD, 8'h5A);
    prefix(19'h78000);
    wr(19'h7D555, 8'hA0);
    wr(19'h4ABCD, 8'h5A);

    // R3 chip erase
    expect_ev(1, 19'h05555, 8'h10);
    six(19'h05555, 8'h10);

    // R4 sector and page erase
    expect_ev(2, 19'h31234, 8'h30);
    six(19'h31234, 8'h30);
    expect_ev(3, 19'h6F0AB, 8'h50);
    six(19'h6F0AB, 8'h50);

    // R5 boot locks
    expect_ev(5, 0, 0);
    six(19'h05555, 8'h40);
    expect_ev(6, 0, 0);
    six(19'h05555, 8'h70);

    // R6 entry and R8 mux
    expect_ev(7, 0, 0);
    prefix('0);
    wr(19'h05555, 8'h90);
    chk(id_mode == 1'b1, "R6 id_mode set", id_mode, 1);
    sw_lock64 = 1'b1; tbl_n = 1'b0; wp_n = 1'b1;
    rd_addr = 19'h0; @(negedge clk);
    chk(rd_data == 8'hDA, "R8 vendor", rd_data, 8'hDA);
    rd_addr = 19'h1; @(negedge clk);
    chk(rd_data == 8'h3D, "R8 device", rd_data, 8'h3D);
    rd_addr = 19'h2; @(negedge clk);
    chk(rd_data == 8'h05, "R8 status", rd_data, 8'h05);
    sw_lock64 = 1'b0; sw_lock16 = 1'b1; tbl_n = 1'b1; wp_n = 1'b0; @(negedge clk);
    chk(rd_data == 8'h0A, "R8 status alt", rd_data, 8'h0A);
    rd_addr = 19'h3; @(negedge clk);
    chk(rd_data == 8'h00, "R8 other address", rd_data, 8'h00);

    // R10 busy single F0 ignored
    busy = 1'b1;
    wr(19'h12345, 8'hF0);
    busy = 1'b0;
    chk(id_mode == 1'b1, "R10 id_mode kept under busy", id_mode, 1);

    // R7 single-byte exit
    expect_ev(8, 0, 0);
    wr(19'h12345, 8'hF0);
    chk(id_mode == 1'b0, "R7 single exit", id_mode, 0);
    rd_addr = 19'h0; arr_rdata = 8'h91; @(negedge clk);
    chk(rd_data == 8'h91, "R8 passthrough after exit", rd_data, 8'h91);

    // R7 prefix exit
    expect_ev(7, 0, 0);
    prefix('0); wr(19'h05555, 8'h90);
    expect_ev(8, 0, 0);
    prefix('0); wr(19'h05555, 8'hF0);
    chk(id_mode == 1'b0, "R7 prefix exit", id_mode, 0);

    // R9 mismatch in prefix: no program follows
    wr(19'h05555, 8'hAA);
    wr(19'h02AAB, 8'h55);
    wr(19'h05555, 8'hA0);
    wr(19'h01000, 8'h00);
    // R9 mismatch at final step of six-write form
    six(19'h05555, 8'h20);
    wr(19'h05555, 8'h10);
    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "R9 no command after mismatch", exp_q.size(), 0);

    // R10 busy write mid-sequence keeps position
    expect_ev(4, 19'h00777, 8'h3C);
    prefix('0);
    busy = 1'b1;
    wr(19'h0FFFF, 8'h77);
    busy = 1'b0;
    wr(19'h05555, 8'hA0);
    wr(19'h00777, 8'h3C);

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R2-R10 all expected strobes seen", exp_q.size(), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule